// File: doc/BRIEF.md
# All-Digital DDS Clock Edge Generator

This block synthesises a clock of programmable frequency entirely in logic. A phase accumulator advances by a frequency word on every clock. Its top bits address a sine table. The resulting stepped sine passes through a fixed symmetric lowpass FIR, which turns it into a smooth sampled waveform, and a zero-crossing detector turns that waveform back into clock edges. Output frequency is `freq_word / 2^ACC_W` times the clock rate.

Each crossing produces a one-cycle rising or falling strobe. A flag marks whether the true crossing lies in the later half of the clock interval, so a downstream delay stage can place the edge to half a clock period. A registered square wave follows the strobes. A programmable divider counts rising strobes and produces a slow trigger pulse, for example a rate of a few hertz from a clock in the megahertz range.

Top module: `dds_edge_gen`

## Requirements
- R1: Reset is synchronous and active high. In every cycle after a clock edge with reset asserted, `sample_o` is 0 and `rise_o`, `fall_o`, `late_half_o`, `clk_o` and `trig_o` are all 0.
- R2: In steady state, the number of rising strobes in a window of W cycles is W·F/2^32, within ±1, where F is the frequency word. A new frequency word is used from the next clock edge.
- R3: Each strobe lasts one cycle. `rise_o` and `fall_o` are never high together, and rising and falling strobes strictly alternate.
- R4: With a frequency word of 0, `sample_o` settles to a constant positive value and no strobe ever occurs.
- R5: Call the value of `sample_o` in cycle k the sample s(k). Sign means bit 11: 1 is negative, 0 is non-negative. `rise_o` is high in cycle k exactly when s(k-2) is negative and s(k-1) is non-negative. `fall_o` is high in cycle k exactly when s(k-2) is non-negative and s(k-1) is negative.
- R6: In a strobe cycle, `late_half_o` is 1 exactly when |s(k-2)| > |s(k-1)|, meaning the crossing lies nearer the later sample. Without a strobe it is 0.
- R7: `clk_o` goes to 1 in the cycle of a rising strobe and to 0 in the cycle of a falling strobe. Otherwise it holds its value.
- R8: With divisor N ≥ 2, `trig_o` pulses for one cycle, in the cycle after every Nth counted rising strobe. With N of 0 or 1, it pulses in the cycle after every rising strobe.
- R9: A clock edge whose divisor input differs from the divisor in use at the previous edge restarts the count at zero. A rising strobe visible just before that edge is not counted.
- R10: `sample_o` always lies within ±2047 (12-bit signed, symmetric saturation). For a tone with a 64-cycle period, the filtered peak exceeds 1800 in both polarities.
- R11: With F = 2^26, consecutive rising strobes are exactly 64 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 32 | Phase increment added every clock |
| div_n | input | 24 | Trigger divisor in rising edges (0 or 1 = every edge) |
| sample_o | output | 12 | Filtered waveform sample, signed |
| rise_o | output | 1 | One-cycle strobe for a negative-to-non-negative crossing |
| fall_o | output | 1 | One-cycle strobe for a non-negative-to-negative crossing |
| late_half_o | output | 1 | The crossing lies in the later half of the interval |
| clk_o | output | 1 | Registered square wave that follows the strobes |
| trig_o | output | 1 | One-cycle divided trigger pulse |

## Verification
A corrupted accumulator or sine entry changes the crossing spacing. This shows at the ports within one output period, either as a rise-to-rise interval other than 64 or as an edge count outside ±1 over a window. A wrong filter tap or a wrong saturation changes `sample_o` within three cycles. Because every strobe and half flag is recomputed from the two samples before it, a detector fault shows in the very next cycle. A divider that skips its restart or miscounts moves `trig_o` by a whole rising-edge period, so the bench sees it one cycle after the rising strobe that should have fired.

// File: rtl/dds_edge_pkg.sv
package dds_edge_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } edge_kind_e;

   // Magnitude of the half-wave sample at position m of 2^(ph_w-1) half-cycle
   // steps, sampled at half-step offsets so both quarters mirror exactly.
   // Rational approximation: 16u/(5 - 4u), u = t(1-t), t in (0,1).
   function automatic longint sine_mag(input int m, input int ph_w, input int maxv);
      longint n;
      longint a;
      longint p;
      n = longint'(1) <<< ph_w;
      a = 2 * longint'(m) + 1;
      p = a * (n - a);
      return (longint'(maxv) * 16 * p) / (5 * n * n - 4 * p);
   endfunction

   // Triangular symmetric coefficient for tap i of an ntap filter.
   function automatic int fir_coef(input int i, input int ntap);
      return ((i + 1) < (ntap - i)) ? (i + 1) : (ntap - i);
   endfunction

   function automatic int fir_gain(input int ntap);
      int s;
      s = 0;
      for (int i = 0; i < ntap; i++) s += fir_coef(i, ntap);
      return s;
   endfunction

endpackage

// File: rtl/dds_nco.sv
module dds_nco #(
   parameter int ACC_W       = 32,
   parameter int PH_W        = 10,
   parameter int AMP_W       = 12,
   parameter bit QUARTER_ROM = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ACC_W-1:0]        freq_word,
   output logic signed [AMP_W-1:0] sine_o
);
   import dds_edge_pkg::*;

   localparam int QW   = PH_W - 2;
   localparam int QN   = 1 << QW;
   localparam int HN   = 1 << (PH_W - 1);
   localparam int FN   = 1 << PH_W;
   localparam int MAXV = (1 << (AMP_W - 1)) - 1;

   logic [ACC_W-1:0] acc_q;
   logic [PH_W-1:0]  phase;

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_q + freq_word;
   end

   assign phase = acc_q[ACC_W-1 -: PH_W];

   generate
      if (QUARTER_ROM) begin : g_quarter
         logic [AMP_W-2:0] qrom [QN];
         logic [QW-1:0]    qidx;
         logic [AMP_W-2:0] mag;

         for (genvar k = 0; k < QN; k++) begin : g_ent
            assign qrom[k] = (AMP_W-1)'(sine_mag(k, PH_W, MAXV));
         end

         always_comb begin
            qidx = phase[PH_W-2] ? ~phase[QW-1:0] : phase[QW-1:0];
            mag  = qrom[qidx];
         end

         always_ff @(posedge clk) begin
            if (rst)                sine_o <= '0;
            else if (phase[PH_W-1]) sine_o <= -$signed({1'b0, mag});
            else                    sine_o <= $signed({1'b0, mag});
         end
      end else begin : g_full
         logic signed [AMP_W-1:0] ftab [FN];

         for (genvar j = 0; j < FN; j++) begin : g_ent
            if (j < HN) begin : g_pos
               assign ftab[j] = AMP_W'(sine_mag(j, PH_W, MAXV));
            end else begin : g_neg
               assign ftab[j] = AMP_W'(-sine_mag(j - HN, PH_W, MAXV));
            end
         end

         always_ff @(posedge clk) begin
            if (rst) sine_o <= '0;
            else     sine_o <= ftab[phase];
         end
      end
   endgenerate

endmodule

// File: rtl/dds_fir_lp.sv
module dds_fir_lp #(
   parameter int AMP_W = 12,
   parameter int NTAP  = 15,
   parameter bit FOLD  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [AMP_W-1:0] x_i,
   output logic signed [AMP_W-1:0] y_o
);
   import dds_edge_pkg::*;

   localparam int HALF  = NTAP / 2;
   localparam int GAIN  = fir_gain(NTAP);
   localparam int SH    = $clog2(GAIN);
   localparam int SUM_W = AMP_W + SH + 1;
   localparam int MAXV  = (1 << (AMP_W - 1)) - 1;
   localparam logic signed [SUM_W-1:0] LIM = SUM_W'(MAXV);

   logic signed [AMP_W-1:0] tap_q [NTAP];
   logic signed [SUM_W-1:0] sum_c;
   logic signed [SUM_W-1:0] sum_q;
   logic signed [SUM_W-1:0] scaled;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NTAP; i++) tap_q[i] <= '0;
      end else begin
         tap_q[0] <= x_i;
         for (int i = 1; i < NTAP; i++) tap_q[i] <= tap_q[i-1];
      end
   end

   generate
      if (FOLD) begin : g_fold
         logic signed [AMP_W:0]   pair [HALF];
         logic signed [SUM_W-1:0] term [HALF+1];

         for (genvar i = 0; i < HALF; i++) begin : g_pair
            localparam logic signed [SUM_W-1:0] CI = SUM_W'(fir_coef(i, NTAP));
            assign pair[i] = {tap_q[i][AMP_W-1], tap_q[i]}
                           + {tap_q[NTAP-1-i][AMP_W-1], tap_q[NTAP-1-i]};
            assign term[i] = SUM_W'(pair[i]) * CI;
         end

         localparam logic signed [SUM_W-1:0] CC = SUM_W'(fir_coef(HALF, NTAP));
         assign term[HALF] = SUM_W'(tap_q[HALF]) * CC;

         always_comb begin
            sum_c = '0;
            for (int i = 0; i <= HALF; i++) sum_c = sum_c + term[i];
         end
      end else begin : g_direct
         logic signed [SUM_W-1:0] term [NTAP];

         for (genvar i = 0; i < NTAP; i++) begin : g_tap
            localparam logic signed [SUM_W-1:0] CI = SUM_W'(fir_coef(i, NTAP));
            assign term[i] = SUM_W'(tap_q[i]) * CI;
         end

         always_comb begin
            sum_c = '0;
            for (int i = 0; i < NTAP; i++) sum_c = sum_c + term[i];
         end
      end
   endgenerate

   assign scaled = sum_q >>> SH;

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q <= '0;
         y_o   <= '0;
      end else begin
         sum_q <= sum_c;
         if (scaled > LIM)       y_o <= AMP_W'(LIM);
         else if (scaled < -LIM) y_o <= AMP_W'(-LIM);
         else                    y_o <= AMP_W'(scaled);
      end
   end

endmodule

// File: rtl/dds_zc_detect.sv
module dds_zc_detect #(
   parameter int AMP_W = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [AMP_W-1:0] smp_i,
   output logic                    rise_o,
   output logic                    fall_o,
   output logic                    late_o,
   output logic                    sq_o
);
   import dds_edge_pkg::*;

   logic signed [AMP_W-1:0] prev_q;
   logic signed [AMP_W:0]   a_ext, b_ext;
   logic [AMP_W:0]          mag_a, mag_b;
   edge_kind_e              kind_c;
   logic                    late_c;

   always_comb begin
      a_ext = {prev_q[AMP_W-1], prev_q};
      b_ext = {smp_i[AMP_W-1], smp_i};
      mag_a = prev_q[AMP_W-1] ? unsigned'(-a_ext) : unsigned'(a_ext);
      mag_b = smp_i[AMP_W-1]  ? unsigned'(-b_ext) : unsigned'(b_ext);
      late_c = mag_a > mag_b;
      if (prev_q[AMP_W-1] && !smp_i[AMP_W-1])      kind_c = EDGE_RISE;
      else if (!prev_q[AMP_W-1] && smp_i[AMP_W-1]) kind_c = EDGE_FALL;
      else                                         kind_c = EDGE_NONE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= '0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
         late_o <= 1'b0;
         sq_o   <= 1'b0;
      end else begin
         prev_q <= smp_i;
         rise_o <= (kind_c == EDGE_RISE);
         fall_o <= (kind_c == EDGE_FALL);
         late_o <= (kind_c != EDGE_NONE) && late_c;
         if (kind_c == EDGE_RISE)      sq_o <= 1'b1;
         else if (kind_c == EDGE_FALL) sq_o <= 1'b0;
      end
   end

endmodule

// File: rtl/dds_trig_div.sv
module dds_trig_div #(
   parameter int DIV_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] div_n,
   output logic             trig_o
);
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;
   logic             wrap_c;

   assign wrap_c = (div_n <= DIV_W'(1)) || (cnt_q == div_n - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q  <= '0;
         cnt_q  <= '0;
         trig_o <= 1'b0;
      end else begin
         div_q  <= div_n;
         trig_o <= 1'b0;
         if (div_n != div_q) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            if (wrap_c) begin
               cnt_q  <= '0;
               trig_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + DIV_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/dds_edge_gen.sv
module dds_edge_gen #(
   parameter int ACC_W       = 32,
   parameter int PH_W        = 10,
   parameter int AMP_W       = 12,
   parameter int NTAP        = 15,
   parameter int DIV_W       = 24,
   parameter bit QUARTER_ROM = 1'b1,
   parameter bit FIR_FOLD    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ACC_W-1:0]        freq_word,
   input  logic [DIV_W-1:0]        div_n,
   output logic signed [AMP_W-1:0] sample_o,
   output logic                    rise_o,
   output logic                    fall_o,
   output logic                    late_half_o,
   output logic                    clk_o,
   output logic                    trig_o
);
   import dds_edge_pkg::*;

   localparam int GAIN = fir_gain(NTAP);
   localparam int SH   = $clog2(GAIN);

   generate
      if (PH_W < 4 || PH_W > 12) begin : g_bad_ph
         $error("PH_W must lie in 4..12");
      end
      if (ACC_W <= PH_W) begin : g_bad_acc
         $error("ACC_W must exceed PH_W");
      end
      if (AMP_W < 8 || AMP_W > 18) begin : g_bad_amp
         $error("AMP_W must lie in 8..18");
      end
      if (NTAP < 3 || (NTAP % 2) != 1) begin : g_bad_ntap
         $error("NTAP must be odd and at least 3");
      end
      if ((1 << SH) != GAIN) begin : g_bad_gain
         $error("filter gain must be a power of two");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
   endgenerate

   logic signed [AMP_W-1:0] sine_s;

   dds_nco #(
      .ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W), .QUARTER_ROM(QUARTER_ROM)
   ) nco_i (
      .clk(clk), .rst(rst), .freq_word(freq_word), .sine_o(sine_s)
   );

   dds_fir_lp #(
      .AMP_W(AMP_W), .NTAP(NTAP), .FOLD(FIR_FOLD)
   ) fir_i (
      .clk(clk), .rst(rst), .x_i(sine_s), .y_o(sample_o)
   );

   dds_zc_detect #(
      .AMP_W(AMP_W)
   ) zc_i (
      .clk(clk), .rst(rst), .smp_i(sample_o),
      .rise_o(rise_o), .fall_o(fall_o), .late_o(late_half_o), .sq_o(clk_o)
   );

   dds_trig_div #(
      .DIV_W(DIV_W)
   ) div_i (
      .clk(clk), .rst(rst), .tick_i(rise_o), .div_n(div_n), .trig_o(trig_o)
   );

endmodule

// File: rtl/dds_edge_gen_chk.sv
module dds_edge_gen_chk #(
   parameter int AMP_W = 12
) (
   input logic                    clk,
   input logic                    rst,
   input logic signed [AMP_W-1:0] sample_o,
   input logic                    rise_o,
   input logic                    fall_o,
   input logic                    late_half_o,
   input logic                    clk_o,
   input logic                    trig_o
);
   import dds_edge_pkg::*;

   localparam int MAXV = (1 << (AMP_W - 1)) - 1;

   logic       rst_q;
   edge_kind_e last_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)         last_q <= EDGE_NONE;
      else if (rise_o) last_q <= EDGE_RISE;
      else if (fall_o) last_q <= EDGE_FALL;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (sample_o == '0 && !rise_o && !fall_o && !late_half_o && !clk_o && !trig_o));

   // R3
   rise_fall_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(rise_o && fall_o));

   // R3
   rise_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
      rise_o |-> (last_q != EDGE_RISE));

   // R3
   fall_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
      fall_o |-> (last_q != EDGE_FALL));

   // R6
   late_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
      late_half_o |-> (rise_o || fall_o));

   // R7
   sq_high_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
      rise_o |-> clk_o);

   // R7
   sq_low_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
      fall_o |-> !clk_o);

   // R7
   sq_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!rise_o && !fall_o) |-> $stable(clk_o));

   // R8
   trig_single_chk: assert property (@(posedge clk) disable iff (rst)
      trig_o |=> !trig_o);

   // R10
   sample_range_chk: assert property (@(posedge clk) disable iff (rst)
      (sample_o <= AMP_W'(MAXV)) && (sample_o >= -AMP_W'(MAXV)));

endmodule

bind dds_edge_gen dds_edge_gen_chk #(.AMP_W(AMP_W)) chk_i (
   .clk(clk), .rst(rst), .sample_o(sample_o), .rise_o(rise_o), .fall_o(fall_o),
   .late_half_o(late_half_o), .clk_o(clk_o), .trig_o(trig_o)
);

// File: tb/dds_edge_gen_tb.sv
module dds_edge_gen_tb_top;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [31:0]        freq_r = '0;
   logic [23:0]        div_r = '0;
   logic signed [11:0] sample_o;
   logic               rise_o, fall_o, late_half_o, clk_o, trig_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   dds_edge_gen dut_i (
      .clk(clk), .rst(rst), .freq_word(freq_r), .div_n(div_r),
      .sample_o(sample_o), .rise_o(rise_o), .fall_o(fall_o),
      .late_half_o(late_half_o), .clk_o(clk_o), .trig_o(trig_o)
   );

   // stimulus / expected table: freq word, divisor, window, rises, triggers, min peak
   localparam int NV = 5;
   localparam logic [31:0] T_F  [NV] = '{32'h0400_0000, 32'd42949673, 32'h0800_0000,
                                          32'd19088743, 32'h1000_0000};
   localparam int          T_N  [NV] = '{0, 4, 3, 2, 7};
   localparam int          T_W  [NV] = '{6400, 10000, 4800, 9000, 1600};
   localparam int          T_ER [NV] = '{100, 100, 150, 40, 100};
   localparam int          T_ET [NV] = '{100, 25, 50, 20, 14};
   localparam int          T_PK [NV] = '{1800, 1800, 1400, 1800, 600};

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   // port-level models
   int  s1, s2, m_cnt, cyc, last_kind;
   bit  m_clk, p_rise;
   int  m_divq;
   int  r_all, t_all, e_all;
   bit  win_on;
   int  rise_w, trig_w, max_w, min_w;

   always @(posedge clk) begin
      bit e_r, e_f, e_l, e_t;
      #2;
      cyc++;
      if (rst) begin
         s1 = 0; s2 = 0; m_clk = 0; m_cnt = 0; m_divq = 0; p_rise = 0; last_kind = 0;
      end else begin
         e_r = (s2 < 0) && (s1 >= 0);
         e_f = (s2 >= 0) && (s1 < 0);
         e_l = (e_r || e_f) && (iabs(s2) > iabs(s1));
         if (e_r || rise_o) chk(rise_o == e_r, "R5 rising strobe", rise_o, e_r);
         if (e_f || fall_o) chk(fall_o == e_f, "R5 falling strobe", fall_o, e_f);
         if (e_l || late_half_o) chk(late_half_o == e_l, "R6 late half flag", late_half_o, e_l);
         if (rise_o) chk(last_kind != 1 && !fall_o, "R3 rise alternates", last_kind, 2);
         if (fall_o) chk(last_kind != 2 && !rise_o, "R3 fall alternates", last_kind, 1);
         if (rise_o) last_kind = 1; else if (fall_o) last_kind = 2;
         if (e_r) m_clk = 1; else if (e_f) m_clk = 0;
         if (e_r || e_f || clk_o != m_clk) chk(clk_o == m_clk, "R7 square output", clk_o, m_clk);
         e_t = 0;
         if (int'(div_r) != m_divq) m_cnt = 0;
         else if (p_rise) begin
            if (div_r <= 1 || m_cnt == int'(div_r) - 1) begin e_t = 1; m_cnt = 0; end
            else m_cnt++;
         end
         m_divq = int'(div_r);
         if (e_t || trig_o) chk(trig_o == e_t, "R8 R9 trigger", trig_o, e_t);
         if (rise_o) r_all++;
         if (trig_o) t_all++;
         if (rise_o || fall_o) e_all++;
         if (win_on) begin
            if (rise_o) rise_w++;
            if (trig_o) trig_w++;
            if (int'(sample_o) > max_w) max_w = int'(sample_o);
            if (int'(sample_o) < min_w) min_w = int'(sample_o);
         end
         s2 = s1; s1 = int'(sample_o); p_rise = rise_o;
      end
   end

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

   task automatic check_reset_outputs(input string tag);
      chk(sample_o == 0, tag, sample_o, 0);
      chk(!rise_o && !fall_o && !late_half_o, tag, {rise_o, fall_o, late_half_o}, 0);
      chk(!clk_o && !trig_o, tag, {clk_o, trig_o}, 0);
   endtask

   initial begin
      int a0, e0, r0, t0, last, n;
      win_on = 0;
      repeat (4) @(negedge clk);
      check_reset_outputs("R1 reset at start");
      rst = 0;

      // R4: zero frequency word
      repeat (50) @(negedge clk);
      a0 = int'(sample_o);
      e0 = e_all;
      repeat (100) @(negedge clk);
      chk(a0 > 0, "R4 constant positive sample", a0, 1);
      chk(int'(sample_o) == a0, "R4 sample stable", sample_o, a0);
      chk(e_all == e0, "R4 no strobes", e_all - e0, 0);

      // table walk: R2, R8, R10
      for (int v = 0; v < NV; v++) begin
         freq_r = T_F[v];
         div_r  = 24'(T_N[v]);
         repeat (300) @(negedge clk);
         rise_w = 0; trig_w = 0; max_w = -100000; min_w = 100000;
         win_on = 1;
         repeat (T_W[v]) @(negedge clk);
         win_on = 0;
         chk(iabs(rise_w - T_ER[v]) <= 1, "R2 rising edge rate", rise_w, T_ER[v]);
         chk(iabs(trig_w - T_ET[v]) <= 1, "R8 trigger rate", trig_w, T_ET[v]);
         chk(max_w >= T_PK[v] && max_w <= 2047, "R10 positive peak", max_w, T_PK[v]);
         chk(min_w <= -T_PK[v] && min_w >= -2047, "R10 negative peak", min_w, -T_PK[v]);
      end

      // R11: exact 64-cycle spacing, divisor 1
      freq_r = 32'h0400_0000;
      div_r  = 24'd1;
      repeat (300) @(negedge clk);
      last = -1; n = 0;
      while (n < 6) begin
         @(negedge clk);
         if (rise_o) begin
            if (last >= 0) chk(cyc - last == 64, "R11 rise spacing", cyc - last, 64);
            last = cyc;
            n++;
         end
      end

      // R9: divisor change restarts the count
      div_r = 24'd3;
      repeat (300) @(negedge clk);
      div_r = 24'd5;
      r0 = r_all; t0 = t_all;
      n = 0;
      while (t_all == t0 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(r_all - r0 == 5, "R9 count restart on divisor change", r_all - r0, 5);

      // R1: reset in mid-run
      repeat (37) @(negedge clk);
      rst = 1;
      @(negedge clk);
      check_reset_outputs("R1 reset mid-run");
      @(negedge clk);
      rst = 0;
      repeat (5) @(negedge clk);

      summary();
      $finish;
   end

endmodule